// File: doc/BRIEF.md
# Quadrature Local Clock Generator

This block turns one fast input clock into two slower local clocks that bus logic can use as a quadrature pair. Each local cycle is split into four quarter phases. Each quarter lasts one input-clock period. The first local clock is high in the first two quarters. The second local clock is high in the middle two quarters, so it trails the first by one quarter. A 2-bit phase output reports which quarter is current, so that neighbouring logic can line up its own actions with the local cycle.

A stretch request can lengthen the local cycle by one input period. The request is looked at only during the third quarter. If it is high there, the fourth quarter (both clocks low) lasts two input cycles instead of one. The other three quarters always last one cycle.

The sequencer is a six-state machine:
- `ST_Q1`, `ST_Q2` and `ST_Q3` are the first three quarters.
- `ST_Q4` is a plain fourth quarter.
- `ST_Q4S` is the first cycle of a stretched fourth quarter.
- `ST_Q4X` is the added cycle of a stretched fourth quarter.

The transitions are:
- `ST_Q1` goes to `ST_Q2`, and `ST_Q2` goes to `ST_Q3`.
- `ST_Q3` goes to `ST_Q4S` when the stretch request is high, and to `ST_Q4` when it is low.
- `ST_Q4S` goes to `ST_Q4X`.
- `ST_Q4` and `ST_Q4X` go to `ST_Q1`.

Reset parks the machine in `ST_Q4`.

Top module: `lclk_quad_gen`

## Requirements
- R1: While `rst_n` is low, `lclk_a` and `lclk_b` are 0 and `phase_q` is 3.
- R2: On the first rising input edge after `rst_n` goes high, the block enters quarter 1: `phase_q` = 0, `lclk_a` = 1, `lclk_b` = 0.
- R3: Without stretch, the quarters run 0,1,2,3,0,… with one input cycle each, so each local clock has a rising-edge period of 4 input cycles.
- R4: `lclk_a` is 1 exactly when `phase_q` is 0 or 1.
- R5: `lclk_b` is 1 exactly when `phase_q` is 1 or 2, so its rising edge comes one input cycle after that of `lclk_a`.
- R6: `phase_q` encodes quarter 1 to quarter 4 as 0 to 3.
- R7: If `stretch_req` is 1 in the cycle where `phase_q` is 2, then `phase_q` stays at 3 for two input cycles and that local period is 5 input cycles.
- R8: `stretch_req` has no effect in any cycle where `phase_q` is not 2.
- R9: All outputs are registers that change only on rising edges of `clk_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stretch_req | input | 1 | Request to lengthen the next fourth quarter |
| lclk_a | output | 1 | Leading local clock |
| lclk_b | output | 1 | Trailing local clock, one quarter behind |
| phase_q | output | 2 | Current quarter, 0 to 3 |

## Verification
The hardest case to reach is a stretch request that arrives in a cycle other than the third quarter, since it must then have no effect. It is also hard to show that a request in the third quarter changes only the fourth quarter that follows it. The driver keeps its own quarter model. It raises the request only where that model says the phase is not 2, pulses it only in phase 2, holds it high throughout, and follows a pseudo-random pattern. Each rising edge of the leading clock is then compared against an expected period of 4 or 5 cycles.

// File: rtl/lqg_pkg.sv
package lqg_pkg;
    localparam int PHASE_W = 2;
    localparam int QUARTERS = 4;
    localparam int NOM_PERIOD = QUARTERS;
    localparam int LONG_PERIOD = QUARTERS + 1;

    typedef enum logic [2:0] {
        ST_Q1  = 3'd0,
        ST_Q2  = 3'd1,
        ST_Q3  = 3'd2,
        ST_Q4  = 3'd3,
        ST_Q4S = 3'd4,
        ST_Q4X = 3'd5
    } lq_state_e;

    function automatic logic [PHASE_W-1:0] quarter_of(lq_state_e st);
        logic [PHASE_W-1:0] q;
        unique case (st)
            ST_Q1:   q = PHASE_W'(0);
            ST_Q2:   q = PHASE_W'(1);
            ST_Q3:   q = PHASE_W'(2);
            default: q = PHASE_W'(3);
        endcase
        return q;
    endfunction
endpackage

// File: rtl/lqg_phase_fsm.sv
module lqg_phase_fsm
    import lqg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stretch_req,
    output lq_state_e state_q,
    output lq_state_e state_d
);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_Q1:  state_d = ST_Q2;
            ST_Q2:  state_d = ST_Q3;
            ST_Q3:  state_d = stretch_req ? ST_Q4S : ST_Q4;
            ST_Q4S: state_d = ST_Q4X;
            ST_Q4:  state_d = ST_Q1;
            ST_Q4X: state_d = ST_Q1;
            default: state_d = ST_Q4;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_Q4;
        else        state_q <= state_d;
    end

    // R7
    stretch_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_Q3 && stretch_req) |=> ##1 (state_q == ST_Q4X));

    // R8
    no_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_Q3 && !stretch_req) |=> ##1 (state_q == ST_Q1));

    // R8
    no_early_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_Q4 || state_q == ST_Q4X) |=> (state_q == ST_Q1));

endmodule

// File: rtl/lqg_out_reg.sv
module lqg_out_reg
    import lqg_pkg::*;
#(
    parameter int PW = PHASE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  lq_state_e     state_d,
    output logic          lclk_a,
    output logic          lclk_b,
    output logic [PW-1:0] phase_q
);

    logic [PW-1:0] phase_d;
    logic          a_d;
    logic          b_d;

    always_comb begin
        phase_d = PW'(quarter_of(state_d));
        a_d = (state_d == ST_Q1) || (state_d == ST_Q2);
        b_d = (state_d == ST_Q2) || (state_d == ST_Q3);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lclk_a  <= 1'b0;
            lclk_b  <= 1'b0;
            phase_q <= PW'(QUARTERS - 1);
        end else begin
            lclk_a  <= a_d;
            lclk_b  <= b_d;
            phase_q <= phase_d;
        end
    end

endmodule

// File: rtl/lclk_quad_gen.sv
module lclk_quad_gen
    import lqg_pkg::*;
(
    input  logic               clk_in,
    input  logic               rst_n,
    input  logic               stretch_req,
    output logic               lclk_a,
    output logic               lclk_b,
    output logic [PHASE_W-1:0] phase_q
);

    lq_state_e state_q;
    lq_state_e state_d;

    lqg_phase_fsm u_fsm (
        .clk         (clk_in),
        .rst_n       (rst_n),
        .stretch_req (stretch_req),
        .state_q     (state_q),
        .state_d     (state_d)
    );

    lqg_out_reg #(.PW(PHASE_W)) u_out (
        .clk     (clk_in),
        .rst_n   (rst_n),
        .state_d (state_d),
        .lclk_a  (lclk_a),
        .lclk_b  (lclk_b),
        .phase_q (phase_q)
    );

    // R1
    always @(negedge clk_in) begin
        if (!rst_n) begin
            reset_idle_chk: assert (!lclk_a && !lclk_b && phase_q == PHASE_W'(3));
        end
    end

    // R3
    seq_step_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (phase_q != PHASE_W'(3)) |=> (phase_q == $past(phase_q) + PHASE_W'(1)));

    // R4
    a_phase_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        lclk_a == (phase_q == PHASE_W'(0) || phase_q == PHASE_W'(1)));

    // R5
    b_phase_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        lclk_b == (phase_q == PHASE_W'(1) || phase_q == PHASE_W'(2)));

    // R6
    phase_state_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        phase_q == quarter_of(state_q));

endmodule

// File: tb/tb_lclk_quad_gen.sv
module tb_lclk_quad_gen;

    typedef struct {
        logic [1:0] ph;
        logic       a;
        logic       b;
        int         per;
        bit         offs;
    } exp_t;

    logic       clk_in = 1'b0;
    logic       rst_n = 1'b1;
    logic       stretch_req = 1'b0;
    logic       lclk_a;
    logic       lclk_b;
    logic [1:0] phase_q;

    int   total = 0;
    int   bad = 0;
    exp_t sb[$];
    bit   drv_done = 0;

    int   m_ph = 3;
    bit   m_pend = 0;
    bit   m_long = 0;
    bit   m_first = 1;

    always #4 clk_in = ~clk_in;

    lclk_quad_gen dut (
        .clk_in      (clk_in),
        .rst_n       (rst_n),
        .stretch_req (stretch_req),
        .lclk_a      (lclk_a),
        .lclk_b      (lclk_b),
        .phase_q     (phase_q)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compute the expected value after the next rising edge and push it.
    task automatic push_next(input bit s);
        exp_t it;
        it.per = 0;
        it.offs = 0;
        if (m_ph == 2) begin
            m_ph = 3;
            m_pend = s;
        end else if (m_ph == 3 && m_pend) begin
            m_pend = 0;
            m_long = 1;
        end else if (m_ph == 3) begin
            m_ph = 0;
            it.per = m_first ? 0 : (m_long ? 5 : 4);
            m_first = 0;
            m_long = 0;
        end else begin
            m_ph = m_ph + 1;
            if (m_ph == 1) it.offs = 1;
        end
        it.ph = 2'(m_ph);
        it.a = (m_ph == 0 || m_ph == 1);
        it.b = (m_ph == 1 || m_ph == 2);
        sb.push_back(it);
    endtask

    task automatic step(input bit s);
        @(negedge clk_in);
        stretch_req = s;
        push_next(s);
    endtask

    // monitor / scoreboard
    initial begin
        int   cyc;
        int   last_a;
        logic pa;
        logic pb;
        logic sa;
        logic sb_;
        logic [1:0] sp;
        cyc = 0;
        last_a = 0;
        pa = 0;
        pb = 0;
        forever begin
            @(posedge clk_in);
            #1;
            cyc++;
            sa = lclk_a;
            sb_ = lclk_b;
            sp = phase_q;
            if (rst_n && sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                // R3 R6 phase sequence
                check(sp == it.ph, "R3/R6 phase", int'(sp), int'(it.ph));
                // R4
                check(sa == it.a, "R4 lclk_a", int'(sa), int'(it.a));
                // R5
                check(sb_ == it.b, "R5 lclk_b", int'(sb_), int'(it.b));
                if (it.per != 0) begin
                    // R3 R7 period between rising edges
                    check(sa && !pa && (cyc - last_a) == it.per,
                          "R3/R7 period", cyc - last_a, it.per);
                end
                if (it.offs) begin
                    // R5 quarter offset
                    check(sb_ && !pb && (cyc - last_a) == 1,
                          "R5 offset", cyc - last_a, 1);
                end
            end
            if (sa && !pa) last_a = cyc;
            pa = sa;
            pb = sb_;
            #2;
            // R9 outputs hold between edges
            if (rst_n) begin
                check(lclk_a == sa && lclk_b == sb_ && phase_q == sp,
                      "R9 stable", int'({lclk_a, lclk_b, phase_q}), int'({sa, sb_, sp}));
            end
        end
    end

    // driver
    initial begin
        logic [7:0] lfsr;
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk_in);
        #2;
        // R1
        check(!lclk_a && !lclk_b && phase_q == 2'd3, "R1 reset",
              int'({lclk_a, lclk_b, phase_q}), 3);
        stretch_req = 1'b1;
        @(posedge clk_in);
        #2;
        // R1 stretch during reset changes nothing
        check(!lclk_a && !lclk_b && phase_q == 2'd3, "R1 reset stretch",
              int'({lclk_a, lclk_b, phase_q}), 3);
        @(negedge clk_in);
        rst_n = 1'b1;
        stretch_req = 1'b0;
        // R2 first quarter after release
        push_next(1'b0);
        // R3 plain run
        for (int i = 0; i < 16; i++) step(1'b0);
        // R8 request everywhere except phase 2
        for (int i = 0; i < 16; i++) step(m_ph != 2);
        // R7 single pulse in phase 2
        for (int i = 0; i < 12; i++) step(m_ph == 2 && i < 4);
        // R7 held high
        for (int i = 0; i < 20; i++) step(1'b1);
        // mixed pseudo-random
        lfsr = 8'hA5;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[0]);
        end
        for (int i = 0; i < 8; i++) step(1'b0);
        @(negedge clk_in);
        @(negedge clk_in);
        drv_done = 1;
    end

    // finish / watchdog
    initial begin
        fork
            wait (drv_done && sb.size() == 0);
            begin
                repeat (100000) @(posedge clk_in);
                check(1'b0, "watchdog", 0, 1);
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule